// File: doc/BRIEF.md
# Keypad Matrix Scanner with Key Event Queue

This block scans a key matrix of up to ten columns and eight rows. It drives one enabled column at a time. After a settle interval it looks at each enabled row of that column, one row per clock. Each key keeps its own debounced state. When a key's sampled level has differed from that state over a programmable number of consecutive scans, the state flips and an event byte is pushed into an eight-entry queue. The host reads the queue through a show-ahead pop interface.

The event byte is built in row-major form. The low three bits carry the row, bits 6..3 carry the column, and bit 7 marks a release. A press at column c, row r therefore reads c*8+r, and the matching release reads the same value with 0x80 added.

Each row has one special function key. While that key is held, the matrix keys on its row are not sampled. At most three matrix keys can be held at once. Two sticky interrupt flags report new events and lost events, and a single status-read strobe clears both.

Top module: `kpd_scan_top`

## Requirements
- R1: Reset clears the queue, both interrupt flags and every debounced key state, so a key still held after reset is reported again as a new press.
- R2: `col_drive` has at most one bit set, and it never sets a bit whose column enable is 0. Column enables are `{col_en_hi, col_en_lo}`, with column 0 at bit 0.
- R3: A debounced press at column c, row r pushes the code c*8+r, with bit 7 = 0.
- R4: A debounced release pushes the press code of the same key with bit 7 set.
- R5: An event is produced only once a key's sampled level has differed from its debounced state on `deb_scans` consecutive visits. A `deb_scans` value of 0 acts as 1, and a shorter mismatch produces nothing.
- R6: Keys on a row whose `row_en` bit is 0, or on a column whose enable bit is 0, produce no event.
- R7: While `spec_key[r]` is 1, matrix keys on row r are not sampled and produce no event. A key on that row still held when `spec_key[r]` falls is reported as a press after debounce.
- R8: With three keys held, a further press produces no event until one held key is released. The release event comes first, then the waiting press.
- R9: The queue holds up to 8 events and returns them in push order. `evt_valid` is 1 whenever it is non-empty, and `pop` removes the entry shown on `evt_data`.
- R10: An event arriving while the queue holds 8 entries is dropped and sets `irq_ovf`. The flag stays set until `sts_read` is pulsed, and the queued entries are unchanged.
- R11: `irq_key` is set by every queued event and stays set until `sts_read` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_en | input | 8 | Row enable mask |
| col_en_lo | input | 8 | Enables for columns 0..7 |
| col_en_hi | input | 2 | Enables for columns 8..9 |
| deb_scans | input | 4 | Consecutive scans needed to accept a change (0 acts as 1) |
| spec_key | input | 8 | Special function key level per row, 1 = held |
| row_sense | input | 8 | Row levels for the driven column, 1 = key closed |
| col_drive | output | 10 | One-hot column drive |
| pop | input | 1 | Remove the head entry of the queue |
| sts_read | input | 1 | Status read strobe, clears both interrupt flags |
| evt_data | output | 8 | Head entry of the queue |
| evt_valid | output | 1 | Queue is non-empty |
| irq_key | output | 1 | Sticky key event flag |
| irq_ovf | output | 1 | Sticky queue overflow flag |

## Verification
With every column enabled, one scan lasts 100 clocks: ten columns of two settle cycles plus eight row visits. A key change is accepted at its `deb_scans`-th visit. The queue then shows the event one clock later.

The bench does not guess where in the scan a stimulus lands. After a press or release it waits one scan period plus a few clocks for each required visit before it expects an entry. For a negative check at threshold N, it samples earlier than (N-1) scans after the stimulus, before the event could possibly be due. Keys whose events must arrive in a given order are changed one at a time, so scan position cannot reorder them.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
    // Scan phase of the column sequencer
    typedef enum logic [0:0] {
        PH_SETTLE = 1'b0,
        PH_VISIT  = 1'b1
    } kpd_phase_e;

    // Event byte layout: {release, column[3:0], row[2:0]}
    localparam int EVT_W     = 8;
    localparam int ROW_FLD_W = 3;
    localparam int COL_FLD_W = 4;
endpackage

// File: rtl/kpd_col_seq.sv
module kpd_col_seq
    import kpd_pkg::*;
#(
    parameter int NCOL       = 10,
    parameter int NROW       = 8,
    parameter int SETTLE_CYC = 2,
    localparam int CW = $clog2(NCOL),
    localparam int RW = $clog2(NROW),
    localparam int SW = $clog2(SETTLE_CYC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCOL-1:0] col_en,
    input  logic [NROW-1:0] row_en,
    output logic [NCOL-1:0] col_drive,
    output logic            visit_vld,
    output logic [CW-1:0]   visit_col,
    output logic [RW-1:0]   visit_row
);
    typedef struct packed {
        kpd_phase_e    phase;
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic [SW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CW-1:0] col_nxt;
    logic          col_on;
    logic          active;

    always_comb begin
        seq_d     = seq_q;
        col_drive = '0;
        visit_vld = 1'b0;
        active    = (|col_en) && (|row_en);
        col_on    = col_en[seq_q.col];
        col_nxt   = (seq_q.col == CW'(NCOL - 1)) ? '0 : seq_q.col + CW'(1);

        if (!active) begin
            seq_d = '{phase: PH_SETTLE, col: '0, row: '0, cnt: '0};
        end else begin
            case (seq_q.phase)
                PH_SETTLE: begin
                    if (!col_on) begin
                        // disabled column: skip it in a single cycle
                        seq_d.col = col_nxt;
                        seq_d.cnt = '0;
                    end else begin
                        col_drive[seq_q.col] = 1'b1;
                        if (seq_q.cnt == SW'(SETTLE_CYC - 1)) begin
                            seq_d.phase = PH_VISIT;
                            seq_d.row   = '0;
                            seq_d.cnt   = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt + SW'(1);
                        end
                    end
                end
                PH_VISIT: begin
                    if (col_on) begin
                        col_drive[seq_q.col] = 1'b1;
                    end
                    visit_vld = col_on && row_en[seq_q.row];
                    if (!col_on || seq_q.row == RW'(NROW - 1)) begin
                        seq_d.phase = PH_SETTLE;
                        seq_d.col   = col_nxt;
                        seq_d.row   = '0;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.row = seq_q.row + RW'(1);
                    end
                end
                default: seq_d.phase = PH_SETTLE;
            endcase
        end
    end

    assign visit_col = seq_q.col;
    assign visit_row = seq_q.row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_SETTLE, col: '0, row: '0, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/kpd_key_track.sv
module kpd_key_track
    import kpd_pkg::*;
#(
    parameter int NCOL     = 10,
    parameter int NROW     = 8,
    parameter int DEB_W    = 4,
    parameter int MAX_HELD = 3,
    localparam int CW   = $clog2(NCOL),
    localparam int RW   = $clog2(NROW),
    localparam int NKEY = NCOL * NROW,
    localparam int KW   = $clog2(NKEY),
    localparam int HW   = $clog2(MAX_HELD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             visit_vld,
    input  logic [CW-1:0]    visit_col,
    input  logic [RW-1:0]    visit_row,
    input  logic             raw_level,
    input  logic             spec_hold,
    input  logic [DEB_W-1:0] deb_scans,
    output logic             ev_vld,
    output logic [EVT_W-1:0] ev_code
);
    typedef struct packed {
        logic [NKEY-1:0]            stable;
        logic [NKEY-1:0][DEB_W-1:0] cnt;
        logic [HW-1:0]              held;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [KW-1:0]    kidx;
    logic [DEB_W-1:0] thr;
    logic [DEB_W-1:0] nc;

    always_comb begin
        trk_d   = trk_q;
        ev_vld  = 1'b0;
        thr     = (deb_scans == '0) ? DEB_W'(1) : deb_scans;
        kidx    = KW'(visit_col) * KW'(NROW) + KW'(visit_row);
        nc      = '0;
        ev_code = {~raw_level, COL_FLD_W'(visit_col), ROW_FLD_W'(visit_row)};

        if (visit_vld && !spec_hold) begin
            if (raw_level == trk_q.stable[kidx]) begin
                trk_d.cnt[kidx] = '0;
            end else begin
                nc = (trk_q.cnt[kidx] == '1) ? trk_q.cnt[kidx]
                                             : trk_q.cnt[kidx] + DEB_W'(1);
                if (nc >= thr) begin
                    if (raw_level && trk_q.held == HW'(MAX_HELD)) begin
                        // press waits for a free slot
                        trk_d.cnt[kidx] = nc;
                    end else begin
                        trk_d.stable[kidx] = raw_level;
                        trk_d.cnt[kidx]    = '0;
                        trk_d.held         = raw_level ? trk_q.held + HW'(1)
                                                       : trk_q.held - HW'(1);
                        ev_vld             = 1'b1;
                    end
                end else begin
                    trk_d.cnt[kidx] = nc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end
endmodule

// File: rtl/kpd_evt_queue.sv
module kpd_evt_queue
    import kpd_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int NW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [EVT_W-1:0] din,
    input  logic             pop,
    input  logic             sts_read,
    output logic [EVT_W-1:0] dout,
    output logic             not_empty,
    output logic             irq_key,
    output logic             irq_ovf
);
    typedef struct packed {
        logic [DEPTH-1:0][EVT_W-1:0] mem;
        logic [AW-1:0]               rd;
        logic [AW-1:0]               wr;
        logic [NW-1:0]               num;
        logic                        key_f;
        logic                        ovf_f;
    } q_t;

    q_t q_d, q_q;
    logic do_push, do_pop;

    always_comb begin
        q_d     = q_q;
        do_pop  = pop && (q_q.num != '0);
        do_push = push && (q_q.num != NW'(DEPTH));

        if (do_push) begin
            q_d.mem[q_q.wr] = din;
            q_d.wr = (q_q.wr == AW'(DEPTH - 1)) ? '0 : q_q.wr + AW'(1);
        end
        if (do_pop) begin
            q_d.rd = (q_q.rd == AW'(DEPTH - 1)) ? '0 : q_q.rd + AW'(1);
        end
        q_d.num = q_q.num + NW'(do_push) - NW'(do_pop);

        if (sts_read) begin
            q_d.key_f = 1'b0;
            q_d.ovf_f = 1'b0;
        end
        if (do_push) begin
            q_d.key_f = 1'b1;
        end
        if (push && !do_push) begin
            q_d.ovf_f = 1'b1;
        end
    end

    assign dout      = q_q.mem[q_q.rd];
    assign not_empty = (q_q.num != '0);
    assign irq_key   = q_q.key_f;
    assign irq_ovf   = q_q.ovf_f;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end
endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top
    import kpd_pkg::*;
#(
    parameter int NCOL       = 10,
    parameter int NROW       = 8,
    parameter int SETTLE_CYC = 2,
    parameter int DEB_W      = 4,
    parameter int MAX_HELD   = 3,
    parameter int QDEPTH     = 8,
    localparam int CW = $clog2(NCOL),
    localparam int RW = $clog2(NROW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NROW-1:0]  row_en,
    input  logic [7:0]       col_en_lo,
    input  logic [1:0]       col_en_hi,
    input  logic [DEB_W-1:0] deb_scans,
    input  logic [NROW-1:0]  spec_key,
    input  logic [NROW-1:0]  row_sense,
    output logic [NCOL-1:0]  col_drive,
    input  logic             pop,
    input  logic             sts_read,
    output logic [EVT_W-1:0] evt_data,
    output logic             evt_valid,
    output logic             irq_key,
    output logic             irq_ovf
);
    logic [NCOL-1:0]  col_en;
    logic             visit_vld;
    logic [CW-1:0]    visit_col;
    logic [RW-1:0]    visit_row;
    logic             raw_level;
    logic             spec_hold;
    logic             ev_vld;
    logic [EVT_W-1:0] ev_code;

    generate
        if (NCOL > 8) begin : g_wide
            assign col_en = {col_en_hi[NCOL-9:0], col_en_lo};
        end else begin : g_narrow
            assign col_en = col_en_lo[NCOL-1:0];
        end
    endgenerate

    always_comb begin
        raw_level = row_sense[visit_row];
        spec_hold = spec_key[visit_row];
    end

    kpd_col_seq #(
        .NCOL(NCOL), .NROW(NROW), .SETTLE_CYC(SETTLE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .col_en(col_en), .row_en(row_en),
        .col_drive(col_drive), .visit_vld(visit_vld),
        .visit_col(visit_col), .visit_row(visit_row)
    );

    kpd_key_track #(
        .NCOL(NCOL), .NROW(NROW), .DEB_W(DEB_W), .MAX_HELD(MAX_HELD)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .visit_vld(visit_vld),
        .visit_col(visit_col), .visit_row(visit_row),
        .raw_level(raw_level), .spec_hold(spec_hold),
        .deb_scans(deb_scans), .ev_vld(ev_vld), .ev_code(ev_code)
    );

    kpd_evt_queue #(
        .DEPTH(QDEPTH)
    ) u_q (
        .clk(clk), .rst_n(rst_n), .push(ev_vld), .din(ev_code),
        .pop(pop), .sts_read(sts_read), .dout(evt_data),
        .not_empty(evt_valid), .irq_key(irq_key), .irq_ovf(irq_ovf)
    );
endmodule

// File: rtl/kpd_scan_chk.sv
module kpd_scan_chk #(
    parameter int NCOL = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCOL-1:0] col_drive,
    input logic [NCOL-1:0] col_en,
    input logic            evt_valid,
    input logic [7:0]      evt_data,
    input logic            irq_key,
    input logic            irq_ovf,
    input logic            sts_read
);
    assert_drive_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_drive));

    assert_drive_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (col_drive & ~col_en) == '0);

    assert_col_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (int'(evt_data[6:3]) < NCOL));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovf && !sts_read) |=> irq_ovf);

    assert_ovf_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ovf) |-> evt_valid);

    assert_key_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_key && !sts_read) |=> irq_key);
endmodule

bind kpd_scan_top kpd_scan_chk #(.NCOL(NCOL)) u_chk (
    .clk(clk), .rst_n(rst_n), .col_drive(col_drive), .col_en(col_en),
    .evt_valid(evt_valid), .evt_data(evt_data), .irq_key(irq_key),
    .irq_ovf(irq_ovf), .sts_read(sts_read)
);

// File: tb/tb_kpd_scan_top.sv
`timescale 1ns/1ps
module tb_kpd_scan_top;
    localparam int SCAN = 10 * (2 + 8);

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] row_en, spec_key, row_sense;
    logic [7:0] col_en_lo;
    logic [1:0] col_en_hi;
    logic [3:0] deb_scans;
    logic [9:0] col_drive;
    logic       pop, sts_read;
    logic [7:0] evt_data;
    logic       evt_valid, irq_key, irq_ovf;
    logic [9:0][7:0] pressed;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    // keypad model: a closed key connects its column drive to its row
    always_comb begin
        row_sense = '0;
        for (int c = 0; c < 10; c++) begin
            if (col_drive[c]) row_sense = row_sense | pressed[c];
        end
    end

    kpd_scan_top dut (
        .clk(clk), .rst_n(rst_n), .row_en(row_en), .col_en_lo(col_en_lo),
        .col_en_hi(col_en_hi), .deb_scans(deb_scans), .spec_key(spec_key),
        .row_sense(row_sense), .col_drive(col_drive), .pop(pop),
        .sts_read(sts_read), .evt_data(evt_data), .evt_valid(evt_valid),
        .irq_key(irq_key), .irq_ovf(irq_ovf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic key(input int c, input int r, input bit v);
        pressed[c][r] = v;
    endtask

    task automatic expect_pop(input int code, input string tag);
        int act;
        act = evt_valid ? int'(evt_data) : 'h1FF;
        chk(evt_valid && evt_data == 8'(code), tag, act, code);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        chk(!evt_valid, tag, evt_valid ? int'(evt_data) : 'h1FF, 'h1FF);
    endtask

    task automatic read_status();
        sts_read = 1'b1;
        @(negedge clk);
        sts_read = 1'b0;
    endtask

    initial begin
        cyc(150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; row_en = 8'hFF; col_en_lo = 8'hFF; col_en_hi = 2'b11;
        deb_scans = 4'd1; spec_key = '0; pressed = '0; pop = 1'b0; sts_read = 1'b0;
        cyc(5);
        chk(!evt_valid && !irq_key && !irq_ovf, "R1 reset outputs",
            {evt_valid, irq_key, irq_ovf}, 0);
        rst_n = 1'b1;
        cyc(1);

        // R2: column drive with columns 8 and 9 disabled
        begin
            int bad = 0;
            logic [9:0] seen = '0;
            col_en_hi = 2'b00;
            for (int i = 0; i < 2 * SCAN; i++) begin
                cyc(1);
                if ($countones(col_drive) > 1 || col_drive[9:8] != 0) bad++;
                seen = seen | col_drive;
            end
            chk(bad == 0, "R2 drive onehot and masked", bad, 0);
            chk(seen == 10'h0FF, "R2 enabled columns driven", int'(seen), 'h0FF);
            col_en_hi = 2'b11;
        end

        // R3/R4: sweep every key, press and release
        for (int c = 0; c < 10; c++) begin
            for (int r = 0; r < 8; r++) begin
                key(c, r, 1); cyc(SCAN + 4);
                expect_pop(c * 8 + r, "R3 press code");
                key(c, r, 0); cyc(SCAN + 4);
                expect_pop('h80 | (c * 8 + r), "R4 release code");
            end
        end
        expect_empty("R9 drained");
        chk(irq_key, "R11 key flag set", irq_key, 1);
        cyc(SCAN);
        chk(irq_key, "R11 key flag held", irq_key, 1);
        read_status();
        chk(!irq_key, "R11 key flag cleared", irq_key, 0);

        // R5: debounce threshold 4
        deb_scans = 4'd4;
        key(5, 5, 1); cyc(2 * SCAN + 50);
        expect_empty("R5 early");
        cyc(2 * SCAN);
        expect_pop('h2D, "R5 after threshold");
        key(5, 5, 0); cyc(5 * SCAN);
        expect_pop('hAD, "R5 release after threshold");
        key(6, 1, 1); cyc(SCAN);
        key(6, 1, 0); cyc(6 * SCAN);
        expect_empty("R5 short glitch");
        deb_scans = 4'd0;
        key(1, 1, 1); cyc(SCAN + 4);
        expect_pop('h09, "R5 zero acts as one");
        key(1, 1, 0); cyc(SCAN + 4);
        expect_pop('h89, "R5 zero acts as one release");

        // R6: masks
        row_en = 8'hFB; col_en_hi = 2'b00;
        key(8, 1, 1); key(3, 2, 1); cyc(3 * SCAN);
        expect_empty("R6 masked keys");
        key(3, 3, 1); cyc(SCAN + 4);
        expect_pop('h1B, "R6 enabled key");
        key(8, 1, 0); key(3, 2, 0); key(3, 3, 0); cyc(SCAN + 4);
        expect_pop('h9B, "R6 enabled release");
        expect_empty("R6 no masked release");
        row_en = 8'hFF; col_en_hi = 2'b11;

        // R7: special key suppresses its row
        spec_key = 8'h04;
        key(4, 2, 1); cyc(2 * SCAN);
        expect_empty("R7 suppressed row");
        key(4, 3, 1); cyc(SCAN + 4);
        expect_pop('h23, "R7 other row");
        spec_key = 8'h00; cyc(SCAN + 4);
        expect_pop('h22, "R7 after special release");
        key(4, 2, 0); cyc(SCAN + 4);
        expect_pop('hA2, "R7 release");
        key(4, 3, 0); cyc(SCAN + 4);
        expect_pop('hA3, "R7 release other");

        // R8: three held keys
        key(0, 0, 1); cyc(SCAN + 4); expect_pop('h00, "R8 first");
        key(1, 0, 1); cyc(SCAN + 4); expect_pop('h08, "R8 second");
        key(2, 0, 1); cyc(SCAN + 4); expect_pop('h10, "R8 third");
        key(3, 0, 1); cyc(2 * SCAN);
        expect_empty("R8 fourth blocked");
        key(0, 0, 0); cyc(2 * SCAN + 4);
        expect_pop('h80, "R8 release first");
        expect_pop('h18, "R8 fourth admitted");
        key(1, 0, 0); cyc(SCAN + 4); expect_pop('h88, "R8 rel");
        key(2, 0, 0); cyc(SCAN + 4); expect_pop('h90, "R8 rel");
        key(3, 0, 0); cyc(SCAN + 4); expect_pop('h98, "R8 rel");

        // R9/R10: fill queue with nine events
        read_status();
        for (int i = 0; i < 9; i++) begin
            key(7, 7, (i % 2) == 0); cyc(SCAN + 4);
        end
        chk(irq_ovf, "R10 overflow flag", irq_ovf, 1);
        cyc(SCAN);
        chk(irq_ovf, "R10 overflow held", irq_ovf, 1);
        for (int i = 0; i < 8; i++) begin
            expect_pop((i % 2) == 0 ? 'h3F : 'hBF, "R9 queue order");
        end
        expect_empty("R10 ninth dropped");
        read_status();
        chk(!irq_ovf && !irq_key, "R10 flags cleared", {irq_ovf, irq_key}, 0);
        key(7, 7, 0); cyc(SCAN + 4);
        expect_pop('hBF, "R10 later event");

        // R1: reset with content and a held key
        key(2, 2, 1); cyc(SCAN + 4);
        chk(evt_valid, "R1 precondition", evt_valid, 1);
        rst_n = 1'b0; cyc(2);
        rst_n = 1'b1; cyc(1);
        chk(!evt_valid && !irq_key, "R1 reset clears", {evt_valid, irq_key}, 0);
        cyc(SCAN + 4);
        expect_pop('h12, "R1 held key reported again");
        key(2, 2, 0); cyc(SCAN + 4);
        expect_pop('h92, "R1 release");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule